// File: doc/BRIEF.md
# Multi-channel DMA register interface

This block is the programmable register front end of an eight-channel DMA controller in the classic PC arrangement. A byte-wide port bus programs each channel's starting address, page byte, transfer length, mode, mask and software request, and reads back the running address and count. Channels 0 to 3 move bytes. Channel 4 is permanently the link to a cascaded controller. Channels 5 to 7 move 16-bit words and keep their address and count in word units.

Every access to an address or count register moves one byte. The byte that moves is chosen by a byte pointer shared by all channels. The pointer is a two-state machine with states `PTR_LO` and `PTR_HI`. It has three transitions: `PTR_LO -> PTR_HI` on an address or count access, `PTR_HI -> PTR_LO` on an address or count access, and any state `-> PTR_LO` on a write to the pointer-clear port. When a transfer engine pulses the transfer strobe for a channel, the block shows that channel's memory address and direction. On the same edge it steps the channel's counters, raises a terminal-count pulse when the count wraps, and then either reloads the channel or masks it.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all eight mask bits are set, no service request is raised, the terminal-count pulse is low, and the byte pointer selects the low byte.
- R2: A write with `bus_fn`=6 returns the byte pointer to the low byte. Every read or write with `bus_fn`=0 (address) or 1 (count) flips the pointer, so the next such access reaches the other byte.
- R3: Writing the address (`bus_fn`=0) or count (`bus_fn`=1) of channel `bus_ch` loads the selected byte of both the base and the current register. Reads always return the current register.
- R4: The page register (`bus_fn`=2) holds bits 23:16 and reads back unchanged. For a byte channel `xfer_addr` = {page, current address}.
- R5: For a word channel (5 to 7) `xfer_addr` = {page[7:1], current address, 0}: the current address is a word address in bits 16:1, and bit 0 of the page is not used.
- R6: Each strobe on a non-cascade channel moves the current address up by one, or down by one when mode bit 5 is set, and moves the current count down by one.
- R7: A strobe taken while the count is zero leaves the count at 0xFFFF and raises `tc_pulse` for exactly one cycle after the strobe. Without auto-initialize, the same strobe sets the channel's mask bit and clears its software request.
- R8: With mode bit 4 (auto-initialize) set, the terminal strobe reloads the current address and count from the base values and leaves the mask bit unchanged.
- R9: A mask write (`bus_fn`=4) targets channel {`bus_ch`[2], data[1:0]}. Data bit 2 = 1 masks the channel and 0 unmasks it. A masked channel raises no service request, whatever its hardware request line does.
- R10: A request write (`bus_fn`=5) uses the same channel selection. Data bit 2 sets or clears the software request, and an unmasked channel with its software request set raises a service request with no hardware request.
- R11: A mode write (`bus_fn`=3) targets channel {`bus_ch`[2], data[1:0]}. Data bits 3:2 are the direction (00 verify, 01 write, 10 read, 11 first-party) and are shown on `xfer_dir`. Data bits 7:6 are the operation (00 demand, 01 single, 10 block, 11 cascade). In cascade a channel ignores address and count writes and strobes, and never raises a service request.
- R12: Channel 4 is always in cascade: mode writes to it have no effect, it never requests service, and its address and count cannot be programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Port write strobe |
| bus_rd | input | 1 | Port read strobe |
| bus_fn | input | 3 | Register function: 0 address, 1 count, 2 page, 3 mode, 4 mask, 5 request, 6 pointer clear |
| bus_ch | input | 3 | Channel for address/count/page; bit 2 picks the controller for mode/mask/request |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (current address/count byte or page) |
| hw_dreq | input | 8 | Hardware request line per channel |
| svc_req | output | 8 | Service request per channel |
| mask_o | output | 8 | Mask bit per channel |
| xfer_stb | input | 1 | One transfer performed on `xfer_ch` |
| xfer_ch | input | 3 | Channel of the transfer strobe |
| xfer_addr | output | 24 | Memory byte address of `xfer_ch` |
| xfer_dir | output | 2 | Direction field of `xfer_ch` |
| tc_pulse | output | 1 | Terminal-count pulse, one cycle after the wrapping strobe |

## Verification
The hardest situation to reach from the ports is a terminal count whose side effects cannot be seen directly. The clearing of the software request at terminal count cannot be seen while the mask is set, so the stimulus unmasks the channel again after the wrap and checks that no request comes back. The auto-initialize reload together with the decrementing address is only visible through the shared byte pointer, so the stimulus clears the pointer and reads back all four bytes. The pointer's response to reads is tested by a read followed by a single write, which must land in the high byte.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        FN_ADDR   = 3'd0,
        FN_COUNT  = 3'd1,
        FN_PAGE   = 3'd2,
        FN_MODE   = 3'd3,
        FN_MASK   = 3'd4,
        FN_REQ    = 3'd5,
        FN_PTRCLR = 3'd6,
        FN_NONE   = 3'd7
    } bus_fn_e;

    typedef enum logic [1:0] {
        OP_DEMAND  = 2'd0,
        OP_SINGLE  = 2'd1,
        OP_BLOCK   = 2'd2,
        OP_CASCADE = 2'd3
    } op_e;

    // Mode byte bits 7:2 in order: op[7:6], dec[5], autoinit[4], dir[3:2]
    typedef struct packed {
        op_e        op;
        logic       dec;
        logic       autoinit;
        logic [1:0] dir;
    } mode_t;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_e;

endpackage

// File: rtl/dmac_byteptr.sv
module dmac_byteptr
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic hi_sel
);

    ptr_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LO: if (clr)       state_d = PTR_LO;
                    else if (step) state_d = PTR_HI;
            PTR_HI: if (clr || step) state_d = PTR_LO;
        endcase
    end

    // outputs
    always_comb begin
        hi_sel = (state_q == PTR_HI);
    end

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int AW            = 16,
    parameter int PW            = 8,
    parameter bit FIXED_CASCADE = 1'b0
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_sel,
    input  logic [7:0]    wdata,
    input  logic          wr_addr,
    input  logic          wr_count,
    input  logic          wr_page,
    input  logic          wr_mode,
    input  logic          mask_we,
    input  logic          req_we,
    input  logic          hw_req,
    input  logic          stb,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic [PW-1:0] page,
    output logic [1:0]    dir,
    output logic          masked,
    output logic          svc,
    output logic          tc
);

    localparam int    BYTE      = 8;
    localparam mode_t CASC_MODE = '{op: OP_CASCADE, dec: 1'b0, autoinit: 1'b0, dir: 2'b00};

    logic [AW-1:0] base_addr, base_cnt;
    mode_t         mode_q, mode_eff;
    logic          sreq;
    logic          is_casc, go, at_zero;

    assign mode_eff = FIXED_CASCADE ? CASC_MODE : mode_q;
    assign is_casc  = (mode_eff.op == OP_CASCADE);
    assign go       = stb && !is_casc;
    assign at_zero  = (cur_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
            page      <= '0;
            mode_q    <= '0;
            masked    <= 1'b1;
            sreq      <= 1'b0;
            tc        <= 1'b0;
        end else begin
            tc <= go && at_zero;
            if (wr_addr && !is_casc) begin
                if (hi_sel) begin
                    base_addr[AW-1:BYTE] <= wdata;
                    cur_addr[AW-1:BYTE]  <= wdata;
                end else begin
                    base_addr[BYTE-1:0]  <= wdata;
                    cur_addr[BYTE-1:0]   <= wdata;
                end
            end
            if (wr_count && !is_casc) begin
                if (hi_sel) begin
                    base_cnt[AW-1:BYTE] <= wdata;
                    cur_cnt[AW-1:BYTE]  <= wdata;
                end else begin
                    base_cnt[BYTE-1:0]  <= wdata;
                    cur_cnt[BYTE-1:0]   <= wdata;
                end
            end
            if (wr_page)                  page   <= wdata;
            if (wr_mode && !FIXED_CASCADE) mode_q <= mode_t'(wdata[7:2]);
            if (mask_we)                  masked <= wdata[2];
            if (req_we)                   sreq   <= wdata[2];
            if (go) begin
                if (at_zero && mode_eff.autoinit) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    cur_addr <= mode_eff.dec ? cur_addr - AW'(1) : cur_addr + AW'(1);
                    cur_cnt  <= cur_cnt - AW'(1);
                    if (at_zero) begin
                        masked <= 1'b1;
                        sreq   <= 1'b0;
                    end
                end
            end
        end
    end

    assign dir = mode_eff.dir;
    assign svc = !masked && !is_casc && (hw_req || sreq);

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int AW         = 16,
    parameter int PW         = 8,
    parameter int CASCADE_CH = 4
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [2:0]             bus_fn,
    input  logic [$clog2(NUM_CH)-1:0] bus_ch,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    input  logic [NUM_CH-1:0]      hw_dreq,
    output logic [NUM_CH-1:0]      svc_req,
    output logic [NUM_CH-1:0]      mask_o,
    input  logic                   xfer_stb,
    input  logic [$clog2(NUM_CH)-1:0] xfer_ch,
    output logic [AW+PW-1:0]       xfer_addr,
    output logic [1:0]             xfer_dir,
    output logic                   tc_pulse
);

    localparam int CW   = $clog2(NUM_CH);
    localparam int SUBW = 2;
    localparam int BYTE = 8;

    bus_fn_e fn;
    logic    acc_ac, ptr_clr, ptr_hi;

    logic [NUM_CH-1:0][AW-1:0]    cur_addr_v, cur_cnt_v;
    logic [NUM_CH-1:0][PW-1:0]    page_v;
    logic [NUM_CH-1:0][AW+PW-1:0] xaddr_v;
    logic [NUM_CH-1:0][1:0]       dir_v;
    logic [NUM_CH-1:0]            tc_v;

    assign fn      = bus_fn_e'(bus_fn);
    assign acc_ac  = (bus_wr || bus_rd) && (fn == FN_ADDR || fn == FN_COUNT);
    assign ptr_clr = bus_wr && (fn == FN_PTRCLR);

    dmac_byteptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ptr_clr),
        .step   (acc_ac),
        .hi_sel (ptr_hi)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam bit IS_WORD  = (i > CASCADE_CH);
        localparam bit IS_FIXED = (i == CASCADE_CH);
        logic hit_dir, hit_ctl;

        assign hit_dir = (bus_ch == CW'(i));
        assign hit_ctl = ({bus_ch[CW-1:SUBW], bus_wdata[SUBW-1:0]} == CW'(i));

        dmac_channel #(
            .AW            (AW),
            .PW            (PW),
            .FIXED_CASCADE (IS_FIXED)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .hi_sel   (ptr_hi),
            .wdata    (bus_wdata),
            .wr_addr  (bus_wr && fn == FN_ADDR  && hit_dir),
            .wr_count (bus_wr && fn == FN_COUNT && hit_dir),
            .wr_page  (bus_wr && fn == FN_PAGE  && hit_dir),
            .wr_mode  (bus_wr && fn == FN_MODE  && hit_ctl),
            .mask_we  (bus_wr && fn == FN_MASK  && hit_ctl),
            .req_we   (bus_wr && fn == FN_REQ   && hit_ctl),
            .hw_req   (hw_dreq[i]),
            .stb      (xfer_stb && xfer_ch == CW'(i)),
            .cur_addr (cur_addr_v[i]),
            .cur_cnt  (cur_cnt_v[i]),
            .page     (page_v[i]),
            .dir      (dir_v[i]),
            .masked   (mask_o[i]),
            .svc      (svc_req[i]),
            .tc       (tc_v[i])
        );

        if (IS_WORD) begin : g_word
            assign xaddr_v[i] = {page_v[i][PW-1:1], cur_addr_v[i], 1'b0};
        end else begin : g_byte
            assign xaddr_v[i] = {page_v[i], cur_addr_v[i]};
        end
    end

    always_comb begin
        case (fn)
            FN_ADDR:  bus_rdata = ptr_hi ? cur_addr_v[bus_ch][AW-1:BYTE] : cur_addr_v[bus_ch][BYTE-1:0];
            FN_COUNT: bus_rdata = ptr_hi ? cur_cnt_v[bus_ch][AW-1:BYTE]  : cur_cnt_v[bus_ch][BYTE-1:0];
            FN_PAGE:  bus_rdata = page_v[bus_ch];
            default:  bus_rdata = '0;
        endcase
    end

    assign xfer_addr = xaddr_v[xfer_ch];
    assign xfer_dir  = dir_v[xfer_ch];
    assign tc_pulse  = |tc_v;

endmodule

// File: rtl/dmac_checker.sv
module dmac_checker
    import dmac_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int CASCADE_CH = 4
)(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [2:0]        bus_fn,
    input logic              ptr_hi,
    input logic [NUM_CH-1:0] svc_req,
    input logic [NUM_CH-1:0] mask_o,
    input logic              xfer_stb,
    input logic              tc_pulse
);

    logic acc, clr;
    assign acc = (bus_wr || bus_rd) && (bus_fn == FN_ADDR || bus_fn == FN_COUNT);
    assign clr = bus_wr && (bus_fn == FN_PTRCLR);

    a_r2_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !ptr_hi);

    a_r2_ptr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (ptr_hi != $past(ptr_hi)));

    a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !clr) |=> $stable(ptr_hi));

    a_r9_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req & mask_o) == '0);

    a_r12_link_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_req[CASCADE_CH]);

    a_r7_tc_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(xfer_stb));

endmodule

bind dmac_regfile dmac_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_fn   (bus_fn),
    .ptr_hi   (ptr_hi),
    .svc_req  (svc_req),
    .mask_o   (mask_o),
    .xfer_stb (xfer_stb),
    .tc_pulse (tc_pulse)
);

// File: tb/sim_dmac_regfile.sv
module sim_dmac_regfile;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_fn = 3'd7, bus_ch = 3'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  hw_dreq = 8'h00;
    logic [7:0]  svc_req, mask_o;
    logic        xfer_stb = 1'b0;
    logic [2:0]  xfer_ch = 3'd0;
    logic [23:0] xfer_addr;
    logic [1:0]  xfer_dir;
    logic        tc_pulse;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_fn(bus_fn), .bus_ch(bus_ch), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_dreq(hw_dreq), .svc_req(svc_req), .mask_o(mask_o),
        .xfer_stb(xfer_stb), .xfer_ch(xfer_ch), .xfer_addr(xfer_addr),
        .xfer_dir(xfer_dir), .tc_pulse(tc_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each read against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard empty", bus_rdata, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    task automatic drive(input bit w, input bit r, input logic [2:0] f,
                         input logic [2:0] c, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = w; bus_rd = r; bus_fn = f; bus_ch = c; bus_wdata = d; xfer_stb = 1'b0;
    endtask

    task automatic wr(input logic [2:0] f, input logic [2:0] c, input logic [7:0] d);
        drive(1'b1, 1'b0, f, c, d);
    endtask

    task automatic rd(input logic [2:0] f, input logic [2:0] c, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        drive(1'b0, 1'b1, f, c, 8'h00);
    endtask

    task automatic settle();
        drive(1'b0, 1'b0, 3'd7, 3'd0, 8'h00);
        @(negedge clk);
    endtask

    task automatic strobe(input logic [2:0] c, input logic [23:0] ea, input logic [1:0] ed, input string t);
        drive(1'b0, 1'b0, 3'd7, 3'd0, 8'h00);
        xfer_stb = 1'b1; xfer_ch = c;
        @(negedge clk);
        chk(xfer_addr == ea, t, xfer_addr, ea);
        chk(xfer_dir == ed, t, xfer_dir, ed);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mask_o == 8'hFF, "R1 masks", mask_o, 8'hFF);
        chk(svc_req == 8'h00, "R1 svc", svc_req, 0);
        chk(tc_pulse == 1'b0, "R1 tc", tc_pulse, 0);
        rd(3'd0, 3'd0, 8'h00, "R1 addr low after reset");
        wr(3'd6, 3'd0, 8'h00);

        // R3 base/current load and readback
        wr(3'd0, 3'd1, 8'h34); wr(3'd0, 3'd1, 8'h12);
        wr(3'd1, 3'd1, 8'h02); wr(3'd1, 3'd1, 8'h00);
        rd(3'd0, 3'd1, 8'h34, "R3 addr lo"); rd(3'd0, 3'd1, 8'h12, "R3 addr hi");
        rd(3'd1, 3'd1, 8'h02, "R3 cnt lo");  rd(3'd1, 3'd1, 8'h00, "R3 cnt hi");

        // R2 reads flip the pointer; clear resets it
        rd(3'd0, 3'd1, 8'h34, "R2 read lo");
        wr(3'd0, 3'd1, 8'hAB);
        rd(3'd0, 3'd1, 8'h34, "R2 lo kept"); rd(3'd0, 3'd1, 8'hAB, "R2 write hit hi");
        rd(3'd0, 3'd1, 8'h34, "R2 pre clear");
        wr(3'd6, 3'd0, 8'h00);
        rd(3'd0, 3'd1, 8'h34, "R2 after clear lo"); rd(3'd0, 3'd1, 8'hAB, "R2 after clear hi");

        // R4 page
        wr(3'd2, 3'd1, 8'h56);
        rd(3'd2, 3'd1, 8'h56, "R4 page readback");

        // R11 mode, R9 mask
        wr(3'd3, 3'd0, 8'h49);
        hw_dreq = 8'h02;
        settle(); chk(svc_req[1] == 1'b0, "R9 masked ignores hw", svc_req[1], 0);
        wr(3'd4, 3'd0, 8'h01);
        settle(); chk(svc_req[1] == 1'b1, "R9 unmasked svc", svc_req[1], 1);
        chk(mask_o[1] == 1'b0, "R9 mask bit clear", mask_o[1], 0);

        // R4/R6/R7 stepping and terminal count
        strobe(3'd1, 24'h56AB34, 2'd2, "R4 R11 strobe 1");
        strobe(3'd1, 24'h56AB35, 2'd2, "R6 strobe 2");
        strobe(3'd1, 24'h56AB36, 2'd2, "R6 strobe 3");
        settle();
        chk(tc_pulse == 1'b1, "R7 tc pulse", tc_pulse, 1);
        chk(mask_o[1] == 1'b1, "R7 mask set", mask_o[1], 1);
        chk(svc_req[1] == 1'b0, "R7 svc dropped", svc_req[1], 0);
        settle(); chk(tc_pulse == 1'b0, "R7 tc one cycle", tc_pulse, 0);
        rd(3'd1, 3'd1, 8'hFF, "R7 cnt lo wrapped"); rd(3'd1, 3'd1, 8'hFF, "R7 cnt hi wrapped");
        rd(3'd0, 3'd1, 8'h37, "R6 addr lo"); rd(3'd0, 3'd1, 8'hAB, "R6 addr hi");

        // R9 mask set via bit 2
        wr(3'd4, 3'd0, 8'h01); settle();
        chk(svc_req[1] == 1'b1, "R9 reunmask", svc_req[1], 1);
        wr(3'd4, 3'd0, 8'h05); settle();
        chk(svc_req[1] == 1'b0, "R9 mask via bit2", svc_req[1], 0);
        hw_dreq = 8'h00;

        // R8 auto-initialize with decrement on channel 2
        wr(3'd3, 3'd0, 8'h76);
        wr(3'd6, 3'd0, 8'h00);
        wr(3'd0, 3'd2, 8'h10); wr(3'd0, 3'd2, 8'h00);
        wr(3'd1, 3'd2, 8'h01); wr(3'd1, 3'd2, 8'h00);
        wr(3'd4, 3'd0, 8'h02);
        strobe(3'd2, 24'h000010, 2'd1, "R8 strobe 1");
        strobe(3'd2, 24'h00000F, 2'd1, "R6 decrement");
        settle();
        chk(tc_pulse == 1'b1, "R8 tc", tc_pulse, 1);
        chk(mask_o[2] == 1'b0, "R8 mask kept", mask_o[2], 0);
        rd(3'd0, 3'd2, 8'h10, "R8 addr reload lo"); rd(3'd0, 3'd2, 8'h00, "R8 addr reload hi");
        rd(3'd1, 3'd2, 8'h01, "R8 cnt reload lo");  rd(3'd1, 3'd2, 8'h00, "R8 cnt reload hi");

        // R10 software request
        wr(3'd5, 3'd0, 8'h06); settle();
        chk(svc_req[2] == 1'b1, "R10 sw req", svc_req[2], 1);
        wr(3'd5, 3'd0, 8'h02); settle();
        chk(svc_req[2] == 1'b0, "R10 sw req clear", svc_req[2], 0);
        wr(3'd5, 3'd0, 8'h07); settle();
        chk(svc_req[3] == 1'b0, "R10 masked sw req", svc_req[3], 0);
        wr(3'd4, 3'd0, 8'h03); settle();
        chk(svc_req[3] == 1'b1, "R10 unmasked sw req", svc_req[3], 1);
        wr(3'd3, 3'd0, 8'h43);
        strobe(3'd3, 24'h000000, 2'd0, "R7 ch3 strobe");
        settle();
        chk(tc_pulse == 1'b1, "R7 ch3 tc", tc_pulse, 1);
        chk(mask_o[3] == 1'b1, "R7 ch3 masked", mask_o[3], 1);
        wr(3'd4, 3'd0, 8'h03); settle();
        chk(svc_req[3] == 1'b0, "R7 sw req cleared at tc", svc_req[3], 0);

        // R5 word channel address form
        wr(3'd2, 3'd5, 8'h03);
        wr(3'd6, 3'd0, 8'h00);
        wr(3'd0, 3'd5, 8'h01); wr(3'd0, 3'd5, 8'h80);
        wr(3'd3, 3'd4, 8'h41);
        strobe(3'd5, 24'h030002, 2'd0, "R5 word address");

        // R11 cascade mode on channel 6
        wr(3'd3, 3'd4, 8'hC2);
        wr(3'd6, 3'd0, 8'h00);
        wr(3'd0, 3'd6, 8'h11); wr(3'd0, 3'd6, 8'h22);
        wr(3'd1, 3'd6, 8'h33); wr(3'd1, 3'd6, 8'h44);
        rd(3'd0, 3'd6, 8'h00, "R11 cascade addr lo"); rd(3'd0, 3'd6, 8'h00, "R11 cascade addr hi");
        rd(3'd1, 3'd6, 8'h00, "R11 cascade cnt lo");  rd(3'd1, 3'd6, 8'h00, "R11 cascade cnt hi");
        wr(3'd4, 3'd4, 8'h02);
        hw_dreq = 8'h40; settle();
        chk(svc_req[6] == 1'b0, "R11 cascade no svc", svc_req[6], 0);
        strobe(3'd6, 24'h000000, 2'd0, "R11 cascade strobe");
        settle(); chk(tc_pulse == 1'b0, "R11 cascade no tc", tc_pulse, 0);
        rd(3'd1, 3'd6, 8'h00, "R11 cascade cnt held lo"); rd(3'd1, 3'd6, 8'h00, "R11 cascade cnt held hi");
        hw_dreq = 8'h00;

        // R11 first-party direction code
        wr(3'd3, 3'd4, 8'h4F);
        strobe(3'd7, 24'h000000, 2'd3, "R11 dir 11");

        // R12 link channel
        wr(3'd3, 3'd4, 8'h40);
        wr(3'd4, 3'd4, 8'h00);
        hw_dreq = 8'h10; settle();
        chk(svc_req[4] == 1'b0, "R12 link no svc", svc_req[4], 0);
        chk(mask_o[4] == 1'b0, "R12 link unmasked", mask_o[4], 0);
        wr(3'd6, 3'd0, 8'h00);
        wr(3'd0, 3'd4, 8'h55); wr(3'd0, 3'd4, 8'h66);
        rd(3'd0, 3'd4, 8'h00, "R12 link addr lo"); rd(3'd0, 3'd4, 8'h00, "R12 link addr hi");
        strobe(3'd4, 24'h000000, 2'd0, "R12 link strobe");
        settle(); chk(tc_pulse == 1'b0, "R12 link no tc", tc_pulse, 0);
        hw_dreq = 8'h00;

        settle();
        if (exp_q.size() != 0) chk(1'b0, "scoreboard leftover", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule